// File: doc/BRIEF.md
# Three-Deep Operand Forwarding Unit

This block picks the two source operands handed to the ALU for the instruction currently in the execute stage of a five-stage, 16-bit, eight-register pipeline. For each operand it takes the source register number and the value read from the register file one stage earlier. It compares that register number against the destination of each of the three older instructions still in flight. When one of them writes that register, its result replaces the stale register-file value.

The register file in this pipeline does not pass a value through when a register is read and written in the same cycle. The block therefore holds its own post-writeback register. That register keeps, for one more cycle, the destination and data that the register file has just written. An older instruction stays visible for three cycles after it leaves execute. Register zero is hard-wired to zero. A source of zero never forwards, and an instruction with no register result carries destination zero, so it never matches.

Top module: `fwd_unit`

## Requirements
- R1: `rf_we` is 1 exactly when `mw_tgt` is non-zero.
- R2: An operand whose source register number is 0 always gets select 0 (`SEL_RF`), and its output equals its register-file input, whatever the destinations hold.
- R3: A non-zero source matching `xm_tgt` gets select 1 and the value `xm_data`, even when the other stages also match.
- R4: A non-zero source that does not match `xm_tgt` but matches `mw_tgt` gets select 2 and the value `mw_data`.
- R5: At each clock edge the post-writeback register loads `mw_tgt`, and it loads `mw_data` when `mw_tgt` is non-zero. A non-zero source that matches only the loaded destination gets select 3 and the data written one cycle earlier.
- R6: A non-zero source that matches no stage gets select 0 and its register-file value.
- R7: After reset the post-writeback destination is 0. No operand gets select 3 until a non-zero destination has passed through the memory/writeback input.
- R8: The two operands are resolved independently. Each one follows R2 to R6 on its own source number, at the same time as the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_idx | input | 3 | First source register number of the instruction in execute |
| src_a_rf | input | 16 | Register-file value read for the first source |
| src_b_idx | input | 3 | Second source register number, already steered in decode |
| src_b_rf | input | 16 | Register-file value read for the second source |
| xm_tgt | input | 3 | Destination of the instruction in the execute/memory register |
| xm_data | input | 16 | ALU output held in the execute/memory register |
| mw_tgt | input | 3 | Destination of the instruction in the memory/writeback register |
| mw_data | input | 16 | Register write data held in the memory/writeback register |
| rf_we | output | 1 | Register-file write enable |
| sel_a | output | 2 | Source choice for the first operand (0 file, 1 ex/mem, 2 mem/wb, 3 post-writeback) |
| sel_b | output | 2 | Source choice for the second operand, same encoding |
| opnd_a | output | 16 | First ALU operand |
| opnd_b | output | 16 | Second ALU operand |

## Verification
The only state is the post-writeback register. A fault in it shows up at the ports on the cycle after the bad capture: a source that matches only the previous writeback destination gets the wrong select or stale data. It can also show up as select 3 where no such write occurred. The comparison and priority paths are combinational, so any error in them appears on `sel_a`, `sel_b`, `opnd_a` or `opnd_b` in the same cycle as the inputs. The sweep therefore covers every source number against every combination of the three destinations.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned NSTG  = 3;
  localparam int unsigned SEL_W = $clog2(NSTG + 1);
  localparam logic [SEL_W-1:0] SEL_RF   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_XM   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MW   = 2'd2;
  localparam logic [SEL_W-1:0] SEL_TAIL = 2'd3;
endpackage

// File: rtl/fwd_tail_reg.sv
module fwd_tail_reg #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_tgt,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] tgt_q,
  output logic [DW-1:0] data_q
);
  logic          data_en;
  logic [AW-1:0] tgt_d;
  logic [DW-1:0] data_d;

  always_comb begin
    data_en = (wr_tgt != '0);
    tgt_d   = wr_tgt;
    data_d  = data_en ? wr_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      data_q <= '0;
    end else begin
      tgt_q  <= tgt_d;
      data_q <= data_d;
    end
  end

  assert_tail_tgt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tgt_q == $past(wr_tgt)));
  assert_tail_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tgt != '0) |=> (data_q == $past(wr_data)));
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             idx,
  input  logic [DW-1:0]             rf_val,
  input  logic [NSTG-1:0][AW-1:0]   stg_tgt,
  input  logic [NSTG-1:0][DW-1:0]   stg_data,
  output logic [SEL_W-1:0]          sel,
  output logic [DW-1:0]             val
);
  // Stage 0 is youngest; scan oldest first so the youngest match wins.
  always_comb begin
    sel = SEL_RF;
    for (int k = NSTG - 1; k >= 0; k--) begin
      if ((idx != '0) && (stg_tgt[k] == idx)) sel = SEL_W'(k + 1);
    end
  end

  always_comb begin
    val = rf_val;
    for (int k = 0; k < NSTG; k++) begin
      if (sel == SEL_W'(k + 1)) val = stg_data[k];
    end
  end

  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |-> (sel == SEL_RF && val == rf_val));
  assert_youngest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0 && idx == stg_tgt[0]) |-> (sel == SEL_XM && val == stg_data[0]));
  assert_file_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RF) |-> (val == rf_val));
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src_a_idx,
  input  logic [DW-1:0]    src_a_rf,
  input  logic [AW-1:0]    src_b_idx,
  input  logic [DW-1:0]    src_b_rf,
  input  logic [AW-1:0]    xm_tgt,
  input  logic [DW-1:0]    xm_data,
  input  logic [AW-1:0]    mw_tgt,
  input  logic [DW-1:0]    mw_data,
  output logic             rf_we,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic [DW-1:0]    opnd_a,
  output logic [DW-1:0]    opnd_b
);
  localparam int unsigned NOPS = 2;

  logic [AW-1:0]             tail_tgt;
  logic [DW-1:0]             tail_data;
  logic [NSTG-1:0][AW-1:0]   stg_tgt;
  logic [NSTG-1:0][DW-1:0]   stg_data;
  logic [NOPS-1:0][AW-1:0]   op_idx;
  logic [NOPS-1:0][DW-1:0]   op_rf;
  logic [NOPS-1:0][SEL_W-1:0] op_sel;
  logic [NOPS-1:0][DW-1:0]   op_val;

  assign rf_we = (mw_tgt != '0);

  fwd_tail_reg #(.DW(DW), .AW(AW)) u_tail (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_tgt  (mw_tgt),
    .wr_data (mw_data),
    .tgt_q   (tail_tgt),
    .data_q  (tail_data)
  );

  always_comb begin
    stg_tgt[0]  = xm_tgt;
    stg_data[0] = xm_data;
    stg_tgt[1]  = mw_tgt;
    stg_data[1] = mw_data;
    stg_tgt[2]  = tail_tgt;
    stg_data[2] = tail_data;
    op_idx[0]   = src_a_idx;
    op_rf[0]    = src_a_rf;
    op_idx[1]   = src_b_idx;
    op_rf[1]    = src_b_rf;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_pick #(.DW(DW), .AW(AW)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (op_idx[g]),
      .rf_val   (op_rf[g]),
      .stg_tgt  (stg_tgt),
      .stg_data (stg_data),
      .sel      (op_sel[g]),
      .val      (op_val[g])
    );
  end

  assign sel_a  = op_sel[0];
  assign sel_b  = op_sel[1];
  assign opnd_a = op_val[0];
  assign opnd_b = op_val[1];

  assert_tail_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SEL_TAIL) |-> (tail_tgt != '0 && tail_tgt == src_a_idx));
  assert_write_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (tail_tgt != '0));
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_a_idx = '0, src_b_idx = '0, xm_tgt = '0, mw_tgt = '0;
  logic [15:0] src_a_rf = '0, src_b_rf = '0, xm_data = '0, mw_data = '0;
  logic        rf_we;
  logic [1:0]  sel_a, sel_b;
  logic [15:0] opnd_a, opnd_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwd_unit u_fwd_unit (
    .clk(clk), .rst_n(rst_n),
    .src_a_idx(src_a_idx), .src_a_rf(src_a_rf),
    .src_b_idx(src_b_idx), .src_b_rf(src_b_rf),
    .xm_tgt(xm_tgt), .xm_data(xm_data),
    .mw_tgt(mw_tgt), .mw_data(mw_data),
    .rf_we(rf_we), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [1:0] exp_sel(input int s, input int x, input int m, input int t);
    if (s == 0) return 2'd0;
    if (s == x) return 2'd1;
    if (s == m) return 2'd2;
    if (s == t) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] s, input int idx);
    if (idx == 0) return "R2";
    case (s)
      2'd1: return "R3";
      2'd2: return "R4";
      2'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: right after reset the post-writeback stage is empty
    @(negedge clk);
    src_a_idx = 3'd5; src_a_rf = 16'h0555; src_b_idx = 3'd0; src_b_rf = 16'h0777;
    #1;
    chk("R7 sel_a", {14'd0, sel_a}, 16'd0);
    chk("R7 opnd_a", opnd_a, 16'h0555);
    chk("R1 idle we", {15'd0, rf_we}, 16'd0);
    chk("R2 reset b", opnd_b, 16'h0777);

    for (int s = 0; s < 8; s++)
      for (int x = 0; x < 8; x++)
        for (int m = 0; m < 8; m++)
          for (int t = 0; t < 8; t++) begin
            logic [11:0] tag;
            logic [1:0]  ea, eb;
            logic [15:0] va, vb, dt;
            int          sb;
            tag = {s[2:0], x[2:0], m[2:0], t[2:0]};
            dt  = {4'hC, tag};
            // cycle 1: the write that lands in the post-writeback stage
            @(negedge clk);
            xm_tgt = 3'd0; mw_tgt = t[2:0]; mw_data = dt;
            #1;
            chk("R1 we", {15'd0, rf_we}, {15'd0, (t != 0)});
            // cycle 2: the forwarding case under test
            @(negedge clk);
            sb = 7 - s;
            xm_tgt = x[2:0]; xm_data = {4'hA, tag};
            mw_tgt = m[2:0]; mw_data = {4'hB, tag};
            src_a_idx = s[2:0]; src_a_rf = {4'h1, tag};
            src_b_idx = sb[2:0]; src_b_rf = {4'h2, tag};
            #1;
            ea = exp_sel(s, x, m, t);
            eb = exp_sel(sb, x, m, t);
            case (ea)
              2'd1: va = xm_data;
              2'd2: va = mw_data;
              2'd3: va = dt;
              default: va = src_a_rf;
            endcase
            case (eb)
              2'd1: vb = xm_data;
              2'd2: vb = mw_data;
              2'd3: vb = dt;
              default: vb = src_b_rf;
            endcase
            chk(req_of(ea, s), {14'd0, sel_a}, {14'd0, ea});
            chk(req_of(ea, s), opnd_a, va);
            chk("R8 b sel", {14'd0, sel_b}, {14'd0, eb});
            chk("R8 b val", opnd_b, vb);
          end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule